// File: doc/BRIEF.md
# Command Buffer Header Decoder

This block walks a command buffer of 32-bit words held in a local memory with a synchronous read port. Each word that stands in header position is decoded by its three top bits and a few reserved patterns. Method headers expand into a burst of method writes, each carrying a subchannel, an 11-bit method word address and one data word taken from the buffer. Jump and call headers move the fetch pointer, and a special return header moves it back to the word that followed the last call.

Software loads a start word pointer with a one-cycle start pulse and then advances a put pointer as it appends words. The decoder fetches only while its read pointer differs from the put pointer, so it idles at the end of the written region and resumes when the put pointer moves on. Method writes leave through a valid/ready port. The block holds a single return slot. A second call made while that slot is occupied, a return made while it is empty, or any header it cannot decode stops the decoder until the next start.

Top module: `cmdbuf_decoder`

## Requirements
- R1: After reset the decoder issues no memory read, presents no method write, is not halted and has both error flags clear until a start pulse arrives.
- R2: A header with bits 31:29 = 0 and a nonzero count in bits 28:18 is followed by that many data words. Each one is emitted as a method write with the subchannel from bits 15:13 and the method address from bits 12:2, and that address is raised by one for each successive data word.
- R3: A header with bits 31:29 = 2 and a nonzero count behaves as in R2, except that every data word of the burst carries the same method address.
- R4: While a method write is valid and ready is low, valid stays high and subchannel, address and data stay unchanged. Each write is delivered exactly once.
- R5: A header word equal to 0x00000000 is skipped without producing any method write.
- R6: A header with bits 31:29 = 1 continues fetching at the word index held in bits 28:2. The word after the jump header is not decoded.
- R7: A header with bits 31:29 = 3 stores the index of the word after it and continues at the word index in bits 28:2. A later header equal to 0x00020000 resumes fetching at the stored index and empties the slot.
- R8: A call that arrives while the return slot is occupied raises the call error flag and halts the decoder.
- R9: A return header that arrives while the return slot is empty raises the return error flag and halts the decoder.
- R10: A header with bits 31:29 of 4 to 7, or a method header with a zero count that is neither 0x00000000 nor 0x00020000, halts the decoder without raising either error flag. A halted decoder reads nothing and emits nothing until it is started again.
- R11: No word is read while the read pointer equals the put pointer, whether the decoder is between headers or in the middle of a burst. Fetching resumes after the put pointer is advanced.
- R12: A start pulse loads the read pointer from the start pointer input, clears both error flags, the halted state and the return slot, and begins fetching a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins decoding at start_ptr_i |
| start_ptr_i | input | AW | Word index of the first header |
| put_ptr_i | input | AW | Word index one past the last valid word |
| mem_rd_en_o | output | 1 | Read request to the buffer memory |
| mem_addr_o | output | AW | Word index being read |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| mth_valid_o | output | 1 | Method write valid |
| mth_ready_i | input | 1 | Method write accepted when high with valid |
| mth_subch_o | output | 3 | Subchannel of the method write |
| mth_addr_o | output | 11 | Method word address |
| mth_data_o | output | 32 | Method data word |
| halt_o | output | 1 | Decoder stopped on an error or an unknown header |
| err_call_o | output | 1 | Call issued while the return slot was occupied |
| err_ret_o | output | 1 | Return issued while the return slot was empty |

## Verification
The bench targets the put pointer landing inside a burst: a decoder that compared it only at header fetch would read stale words beyond the written region and emit extra writes. Calls and returns are run in an order where the called routine finishes before the caller's own methods. A wrong saved index would replay the call header or skip a method. Nested calls, unmatched returns and both kinds of malformed header must each halt with the correct flag pattern. Repeated restarts check that a stale return slot or a leftover error does not survive a start pulse. A stalled ready line with changing memory data checks that a design forwarding the read port straight to the output would show a changing value.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 11;
    localparam int MADDR_W = 11;
    localparam int SUBCH_W = 3;
    localparam int TGT_W   = 27;

    localparam logic [2:0] OP_MINC = 3'd0;
    localparam logic [2:0] OP_JUMP = 3'd1;
    localparam logic [2:0] OP_MFIX = 3'd2;
    localparam logic [2:0] OP_CALL = 3'd3;

    localparam logic [WORD_W-1:0] HDR_NOP = 32'h0000_0000;
    localparam logic [WORD_W-1:0] HDR_RET = 32'h0002_0000;

    typedef enum logic [2:0] {
        HK_NOP, HK_RET, HK_MINC, HK_MFIX, HK_JUMP, HK_CALL, HK_BAD
    } hdr_kind_e;

    typedef struct packed {
        hdr_kind_e            kind;
        logic [CNT_W-1:0]     cnt;
        logic [SUBCH_W-1:0]   subch;
        logic [MADDR_W-1:0]   maddr;
        logic [TGT_W-1:0]     target;
    } hdr_info_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_HDEC, ST_DREQ, ST_DCAP, ST_DOUT, ST_HALT
    } dec_state_e;

endpackage

// File: rtl/cmdbuf_hdr_dec.sv
module cmdbuf_hdr_dec
    import cmdbuf_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output hdr_info_t         info_o
);

    logic [2:0]       op;
    logic [CNT_W-1:0] cnt;

    assign op  = word_i[31:29];
    assign cnt = word_i[28:18];

    always_comb begin
        info_o.cnt    = cnt;
        info_o.subch  = word_i[15:13];
        info_o.maddr  = word_i[12:2];
        info_o.target = word_i[28:2];
        if (word_i == HDR_NOP) begin
            info_o.kind = HK_NOP;
        end else if (word_i == HDR_RET) begin
            info_o.kind = HK_RET;
        end else begin
            case (op)
                OP_MINC: info_o.kind = (cnt == '0) ? HK_BAD : HK_MINC;
                OP_MFIX: info_o.kind = (cnt == '0) ? HK_BAD : HK_MFIX;
                OP_JUMP: info_o.kind = HK_JUMP;
                OP_CALL: info_o.kind = HK_CALL;
                default: info_o.kind = HK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/cmdbuf_ret_slot.sv
module cmdbuf_ret_slot #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_ptr_i,
    output logic          valid_o,
    output logic [AW-1:0] ptr_o
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] ptr;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr_i) begin
            slot_d.valid = 1'b0;
        end else if (push_i) begin
            slot_d.valid = 1'b1;
            slot_d.ptr   = push_ptr_i;
        end else if (pop_i) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign ptr_o   = slot_q.ptr;

endmodule

// File: rtl/cmdbuf_decoder.sv
module cmdbuf_decoder
    import cmdbuf_pkg::*;
#(
    parameter int AW = 16   // word index width, at most TGT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [AW-1:0]      start_ptr_i,
    input  logic [AW-1:0]      put_ptr_i,
    output logic               mem_rd_en_o,
    output logic [AW-1:0]      mem_addr_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic               mth_valid_o,
    input  logic               mth_ready_i,
    output logic [SUBCH_W-1:0] mth_subch_o,
    output logic [MADDR_W-1:0] mth_addr_o,
    output logic [WORD_W-1:0]  mth_data_o,
    output logic               halt_o,
    output logic               err_call_o,
    output logic               err_ret_o
);

    typedef struct packed {
        dec_state_e         st;
        logic [AW-1:0]      rd_ptr;
        logic [CNT_W-1:0]   left;
        logic [MADDR_W-1:0] maddr;
        logic [SUBCH_W-1:0] subch;
        logic               step;
        logic [WORD_W-1:0]  data;
        logic               err_call;
        logic               err_ret;
    } dec_regs_t;

    dec_regs_t r_d, r_q;

    hdr_info_t     info;
    logic          at_put;
    logic          rd_en;
    logic          slot_push, slot_pop, slot_clr;
    logic          slot_valid;
    logic [AW-1:0] slot_ptr;

    cmdbuf_hdr_dec u_hdr_dec (
        .word_i (mem_rdata_i),
        .info_o (info)
    );

    cmdbuf_ret_slot #(.AW(AW)) u_ret_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (slot_clr),
        .push_i     (slot_push),
        .pop_i      (slot_pop),
        .push_ptr_i (r_q.rd_ptr),
        .valid_o    (slot_valid),
        .ptr_o      (slot_ptr)
    );

    assign at_put = (r_q.rd_ptr == put_ptr_i);

    always_comb begin
        r_d       = r_q;
        rd_en     = 1'b0;
        slot_push = 1'b0;
        slot_pop  = 1'b0;
        slot_clr  = 1'b0;
        case (r_q.st)
            ST_HREQ: begin
                if (!at_put) begin
                    rd_en    = 1'b1;
                    r_d.rd_ptr = r_q.rd_ptr + AW'(1);
                    r_d.st   = ST_HDEC;
                end
            end
            ST_HDEC: begin
                r_d.st = ST_HREQ;
                case (info.kind)
                    HK_NOP: ;
                    HK_RET: begin
                        if (slot_valid) begin
                            r_d.rd_ptr = slot_ptr;
                            slot_pop   = 1'b1;
                        end else begin
                            r_d.err_ret = 1'b1;
                            r_d.st      = ST_HALT;
                        end
                    end
                    HK_MINC, HK_MFIX: begin
                        r_d.left  = info.cnt;
                        r_d.maddr = info.maddr;
                        r_d.subch = info.subch;
                        r_d.step  = (info.kind == HK_MINC);
                        r_d.st    = ST_DREQ;
                    end
                    HK_JUMP: r_d.rd_ptr = info.target[AW-1:0];
                    HK_CALL: begin
                        if (slot_valid) begin
                            r_d.err_call = 1'b1;
                            r_d.st       = ST_HALT;
                        end else begin
                            slot_push  = 1'b1;
                            r_d.rd_ptr = info.target[AW-1:0];
                        end
                    end
                    default: r_d.st = ST_HALT;
                endcase
            end
            ST_DREQ: begin
                if (!at_put) begin
                    rd_en      = 1'b1;
                    r_d.rd_ptr = r_q.rd_ptr + AW'(1);
                    r_d.st     = ST_DCAP;
                end
            end
            ST_DCAP: begin
                r_d.data = mem_rdata_i;
                r_d.st   = ST_DOUT;
            end
            ST_DOUT: begin
                if (mth_ready_i) begin
                    r_d.left  = r_q.left - CNT_W'(1);
                    r_d.maddr = r_q.maddr + MADDR_W'(r_q.step);
                    r_d.st    = (r_q.left == CNT_W'(1)) ? ST_HREQ : ST_DREQ;
                end
            end
            default: ;
        endcase
        if (start_i) begin
            rd_en        = 1'b0;
            slot_push    = 1'b0;
            slot_pop     = 1'b0;
            slot_clr     = 1'b1;
            r_d.st       = ST_HREQ;
            r_d.rd_ptr   = start_ptr_i;
            r_d.err_call = 1'b0;
            r_d.err_ret  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_en_o = rd_en;
    assign mem_addr_o  = r_q.rd_ptr;
    assign mth_valid_o = (r_q.st == ST_DOUT);
    assign mth_subch_o = r_q.subch;
    assign mth_addr_o  = r_q.maddr;
    assign mth_data_o  = r_q.data;
    assign halt_o      = (r_q.st == ST_HALT);
    assign err_call_o  = r_q.err_call;
    assign err_ret_o   = r_q.err_ret;

endmodule

// File: rtl/cmdbuf_decoder_chk.sv
module cmdbuf_decoder_chk
    import cmdbuf_pkg::*;
#(
    parameter int AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [AW-1:0]      put_ptr_i,
    input logic               mem_rd_en_o,
    input logic [AW-1:0]      mem_addr_o,
    input logic               mth_valid_o,
    input logic               mth_ready_i,
    input logic [SUBCH_W-1:0] mth_subch_o,
    input logic [MADDR_W-1:0] mth_addr_o,
    input logic [WORD_W-1:0]  mth_data_o,
    input logic               halt_o,
    input logic               err_call_o,
    input logic               err_ret_o
);

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mth_valid_o && !mth_ready_i && !start_i) |=> mth_valid_o); // R4

    AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mth_valid_o && !mth_ready_i && !start_i) |=>
        ($stable(mth_data_o) && $stable(mth_addr_o) && $stable(mth_subch_o))); // R4

    AST_NO_READ_AT_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (mem_addr_o != put_ptr_i)); // R11

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!mem_rd_en_o && !mth_valid_o)); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !start_i) |=> halt_o); // R10

    AST_CALL_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_call_o) |-> halt_o); // R8

    AST_RET_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ret_o) |-> halt_o); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!halt_o && !err_call_o && !err_ret_o)); // R12

endmodule

bind cmdbuf_decoder cmdbuf_decoder_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .put_ptr_i   (put_ptr_i),
    .mem_rd_en_o (mem_rd_en_o),
    .mem_addr_o  (mem_addr_o),
    .mth_valid_o (mth_valid_o),
    .mth_ready_i (mth_ready_i),
    .mth_subch_o (mth_subch_o),
    .mth_addr_o  (mth_addr_o),
    .mth_data_o  (mth_data_o),
    .halt_o      (halt_o),
    .err_call_o  (err_call_o),
    .err_ret_o   (err_ret_o)
);

// File: tb/cmdbuf_decoder_tb_top.sv
module cmdbuf_decoder_tb_top;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_ptr = '0;
    logic [AW-1:0] put_ptr = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rdata = '0;
    logic          valid;
    logic          ready;
    logic [2:0]    subch;
    logic [10:0]   maddr;
    logic [31:0]   mdata;
    logic          halt, err_call, err_ret;

    logic [31:0] mem [DEPTH];

    logic hold_low = 1'b0;
    logic bp_en = 1'b0;
    logic [1:0] bp_ctr = '0;
    assign ready = !hold_low && (!bp_en || bp_ctr[1]);

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int          cap_n = 0;
    logic [2:0]  cap_sc   [64];
    logic [10:0] cap_addr [64];
    logic [31:0] cap_data [64];

    always #10 clk = ~clk;

    cmdbuf_decoder #(.AW(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_ptr_i (start_ptr),
        .put_ptr_i   (put_ptr),
        .mem_rd_en_o (rd_en),
        .mem_addr_o  (rd_addr),
        .mem_rdata_i (rdata),
        .mth_valid_o (valid),
        .mth_ready_i (ready),
        .mth_subch_o (subch),
        .mth_addr_o  (maddr),
        .mth_data_o  (mdata),
        .halt_o      (halt),
        .err_call_o  (err_call),
        .err_ret_o   (err_ret)
    );

    always @(posedge clk) begin
        if (rd_en) rdata <= mem[rd_addr];
        else       rdata <= 32'hDEAD_0000 + 32'(cycles);
        if (rst_n && valid && ready && cap_n < 64) begin
            cap_sc[cap_n]   <= subch;
            cap_addr[cap_n] <= maddr;
            cap_data[cap_n] <= mdata;
            cap_n <= cap_n + 1;
        end
    end

    always @(negedge clk) begin
        bp_ctr <= bp_ctr + 2'd1;
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    function automatic logic [31:0] h_mth(input logic [2:0] op, input int cnt,
                                          input int sc, input int ma);
        return {op, 11'(cnt), 2'b00, 3'(sc), 11'(ma), 2'b00};
    endfunction

    function automatic logic [31:0] h_ptr(input logic [2:0] op, input int tgt);
        return {op, 27'(tgt), 2'b00};
    endfunction

    task automatic mem_clear();
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    endtask

    task automatic settle();
        int quiet = 0;
        for (int i = 0; i < 4000 && quiet < 12; i++) begin
            @(negedge clk);
            if (!rd_en && !valid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic go(input int sp, input int pp);
        @(negedge clk);
        start_ptr = AW'(sp);
        put_ptr   = AW'(pp);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic exp_cap(input int idx, input int sc, input int ma,
                           input logic [31:0] d, input string req);
        chk_eq(req, "subch", 32'(cap_sc[idx]), 32'(sc));
        chk_eq(req, "maddr", 32'(cap_addr[idx]), 32'(ma));
        chk_eq(req, "data", cap_data[idx], d);
    endtask

    task automatic t_reset();
        chk_eq("R1", "rd_en", 32'(rd_en), 0);
        chk_eq("R1", "valid", 32'(valid), 0);
        chk_eq("R1", "halt", 32'(halt), 0);
        chk_eq("R1", "errors", {30'd0, err_call, err_ret}, 0);
    endtask

    task automatic t_inc_burst();
        int base;
        mem_clear();
        mem[0] = h_mth(3'd0, 3, 5, 11'h7FE);
        mem[1] = 32'hA000_0001;
        mem[2] = 32'hA000_0002;
        mem[3] = 32'hA000_0003;
        base = cap_n;
        bp_en = 1'b1;
        go(0, 4);
        settle();
        bp_en = 1'b0;
        chk_eq("R2", "count", 32'(cap_n - base), 3);
        exp_cap(base,     5, 11'h7FE, 32'hA000_0001, "R2");
        exp_cap(base + 1, 5, 11'h7FF, 32'hA000_0002, "R2");
        exp_cap(base + 2, 5, 11'h000, 32'hA000_0003, "R2");
        chk_eq("R11", "idle at put not halted", 32'(halt), 0);
    endtask

    task automatic t_fix_burst_nop();
        int base;
        mem_clear();
        mem[10] = 32'h0;
        mem[11] = 32'h0;
        mem[12] = h_mth(3'd2, 2, 1, 11'h123);
        mem[13] = 32'hB000_0001;
        mem[14] = 32'hB000_0002;
        base = cap_n;
        go(10, 15);
        settle();
        chk_eq("R5", "nop skipped count", 32'(cap_n - base), 2);
        exp_cap(base,     1, 11'h123, 32'hB000_0001, "R3");
        exp_cap(base + 1, 1, 11'h123, 32'hB000_0002, "R3");
    endtask

    task automatic t_backpressure();
        int base;
        logic [31:0] d0;
        logic [10:0] a0;
        mem_clear();
        mem[20] = h_mth(3'd0, 2, 7, 11'h40);
        mem[21] = 32'hC000_0001;
        mem[22] = 32'hC000_0002;
        base = cap_n;
        hold_low = 1'b1;
        go(20, 23);
        for (int i = 0; i < 20 && !valid; i++) @(negedge clk);
        d0 = mdata;
        a0 = maddr;
        repeat (6) @(negedge clk);
        chk_eq("R4", "valid held", 32'(valid), 1);
        chk_eq("R4", "data held", mdata, d0);
        chk_eq("R4", "addr held", 32'(maddr), 32'(a0));
        hold_low = 1'b0;
        settle();
        chk_eq("R4", "delivered once", 32'(cap_n - base), 2);
        exp_cap(base + 1, 7, 11'h41, 32'hC000_0002, "R4");
    endtask

    task automatic t_jump();
        int base;
        mem_clear();
        mem[0]  = h_ptr(3'd1, 40);
        mem[1]  = h_mth(3'd0, 1, 2, 3);
        mem[2]  = 32'hEEEE_EEEE;
        mem[40] = h_mth(3'd0, 1, 4, 11'h55);
        mem[41] = 32'hD000_0001;
        base = cap_n;
        go(0, 42);
        settle();
        chk_eq("R6", "count", 32'(cap_n - base), 1);
        exp_cap(base, 4, 11'h55, 32'hD000_0001, "R6");
    endtask

    task automatic t_call_return();
        int base;
        mem_clear();
        mem[0]  = h_ptr(3'd3, 30);
        mem[1]  = h_mth(3'd0, 1, 3, 11'h20);
        mem[2]  = 32'hA5A5_0001;
        mem[30] = h_mth(3'd0, 1, 2, 11'h10);
        mem[31] = 32'hB6B6_0001;
        mem[32] = 32'h0002_0000;
        base = cap_n;
        go(0, 3);
        settle();
        chk_eq("R7", "count", 32'(cap_n - base), 2);
        exp_cap(base,     2, 11'h10, 32'hB6B6_0001, "R7");
        exp_cap(base + 1, 3, 11'h20, 32'hA5A5_0001, "R7");
        chk_eq("R7", "no error", {30'd0, err_call, err_ret}, 0);
    endtask

    task automatic t_nested_call();
        int base;
        mem_clear();
        mem[0]  = h_ptr(3'd3, 10);
        mem[10] = h_ptr(3'd3, 20);
        mem[20] = h_mth(3'd0, 1, 0, 0);
        mem[21] = 32'h1;
        base = cap_n;
        go(0, 30);
        settle();
        chk_eq("R8", "halt", 32'(halt), 1);
        chk_eq("R8", "err_call", 32'(err_call), 1);
        chk_eq("R8", "err_ret", 32'(err_ret), 0);
        chk_eq("R8", "no writes", 32'(cap_n - base), 0);
    endtask

    task automatic t_bad_return();
        mem_clear();
        mem[5] = 32'h0002_0000;
        go(5, 9);
        settle();
        chk_eq("R9", "halt", 32'(halt), 1);
        chk_eq("R9", "err_ret", 32'(err_ret), 1);
        chk_eq("R9", "err_call", 32'(err_call), 0);
    endtask

    task automatic t_restart();
        int base;
        mem_clear();
        mem[60] = h_mth(3'd0, 1, 6, 11'h77);
        mem[61] = 32'hF000_0001;
        base = cap_n;
        go(60, 62);
        chk_eq("R12", "halt cleared", 32'(halt), 0);
        chk_eq("R12", "errors cleared", {30'd0, err_call, err_ret}, 0);
        settle();
        exp_cap(base, 6, 11'h77, 32'hF000_0001, "R12");
        mem[50] = h_ptr(3'd3, 55);
        go(50, 55);
        settle();
        mem[70] = 32'h0002_0000;
        go(70, 72);
        settle();
        chk_eq("R12", "slot cleared by start", 32'(err_ret), 1);
    endtask

    task automatic t_unknown();
        int base;
        mem_clear();
        mem[0] = 32'h8000_0000;
        mem[1] = h_mth(3'd0, 1, 0, 0);
        mem[2] = 32'h1;
        base = cap_n;
        go(0, 3);
        settle();
        chk_eq("R10", "op4 halt", 32'(halt), 1);
        chk_eq("R10", "op4 no flags", {30'd0, err_call, err_ret}, 0);
        chk_eq("R10", "op4 no writes", 32'(cap_n - base), 0);
        mem[8] = h_mth(3'd0, 0, 1, 5);
        mem[9] = h_mth(3'd0, 1, 0, 0);
        go(8, 12);
        settle();
        chk_eq("R10", "zero count halt", 32'(halt), 1);
        chk_eq("R10", "zero count no writes", 32'(cap_n - base), 0);
    endtask

    task automatic t_put_mid_burst();
        int base;
        mem_clear();
        mem[0] = h_mth(3'd0, 3, 2, 11'h100);
        mem[1] = 32'h9000_0001;
        mem[2] = 32'h9000_0002;
        mem[3] = 32'h9000_0003;
        base = cap_n;
        go(0, 2);
        settle();
        chk_eq("R11", "stopped mid burst", 32'(cap_n - base), 1);
        chk_eq("R11", "not halted", 32'(halt), 0);
        @(negedge clk);
        put_ptr = AW'(4);
        settle();
        chk_eq("R11", "resumed count", 32'(cap_n - base), 3);
        exp_cap(base + 2, 2, 11'h102, 32'h9000_0003, "R11");
    endtask

    initial begin
        mem_clear();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_inc_burst();
        t_fix_burst_nop();
        t_backpressure();
        t_jump();
        t_call_return();
        t_nested_call();
        t_bad_return();
        t_restart();
        t_unknown();
        t_put_mid_burst();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule